// File: doc/BRIEF.md
# Digital Horizontal Line-Lock Loop

This block keeps a local line-rate timebase in step with the horizontal sync carried in a stream of digitized, band-limited luminance samples. Each sample period is marked by a clock enable. The block compares each sample with a programmable threshold. When the signal drops below that threshold, the block takes this as a sync edge. It then measures where that edge lands relative to the wrap point of a fractional line counter, which is a numerically controlled oscillator. The signed distance feeds a proportional-plus-integral loop filter. The filter output trims the oscillator increment, and that increment is presented as the line-frequency control word.

One input selects the line length: 432 sample periods per line for 50 Hz standards, or 429 for 60 Hz standards. The oscillator emits a one-cycle line-start strobe at every wrap. The block declares lock after a run of lines whose phase error stays inside a programmable window. Once locked, it treats any sync-like edge far from the predicted position as a pseudo-sync. It reports such edges through a per-line flag and keeps them out of the loop. If no sync edge arrives for a line and a half, the oscillator free-runs on the stored integrator.

Top module: `llk_line_lock`

## Requirements
- R1: After reset, line_start, locked and pseudo_seen are 0 and freq_word equals the nominal increment 2^FRAC (4096).
- R2: A sync edge is a sampled luma value below slice_lvl that directly follows a sample at or above slice_lvl. A luma value equal to slice_lvl is not below it.
- R3: Without sync edges, and with the integrator at zero, line_start pulses every 432 enabled samples when std60=0, and every 429 enabled samples when std60=1.
- R4: The phase error of an accepted edge is line_pos when line_pos < M/2, and line_pos-M otherwise, where M is the line length. The integrator adds (err·2^FRAC)>>>ki_shift and is clamped to ±2^(FRAC-1). The control value u is the new integrator plus (err·2^FRAC)>>>kp_shift, with the same clamp. freq_word = 2^FRAC-u. As a result, the mean line period follows the sync period, and sync slower than nominal drives freq_word below 4096.
- R5: locked rises after 16 consecutive line events whose |err| ≤ lock_win. It falls after 4 consecutive line events that are out of the window. A timeout counts as an out-of-window event.
- R6: If no edge is accepted for 3M/2 enabled samples (integer division), a timeout event occurs. The loop then runs with freq_word = 2^FRAC minus the stored integrator.
- R7: While locked, an edge with |err| > M/10 (integer division: 43 or 42) is a pseudo-sync. It changes neither the loop nor the lock counters. One cycle after each line_start, pseudo_seen shows whether any pseudo-sync occurred in the line that just ended.
- R8: While unlocked, every edge is used by the loop and none is reported as pseudo-sync.
- R9: freq_word always stays within [2^(FRAC-1), 3·2^(FRAC-1)], which is [2048, 6144].
- R10: When smp_en is low, the oscillator, slicer and timeout counter hold, so a gap of G cycles lengthens the current line by G cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_en | input | 1 | Sample-period clock enable |
| luma | input | LW (8) | Low-passed luminance sample |
| slice_lvl | input | LW (8) | Sync slicing threshold |
| std60 | input | 1 | 0: 432-sample lines, 1: 429-sample lines |
| kp_shift | input | SHW (4) | Proportional gain as a right shift |
| ki_shift | input | SHW (4) | Integral gain as a right shift |
| lock_win | input | WINW (8) | Lock window on absolute phase error, in samples |
| line_start | output | 1 | One-cycle strobe at each oscillator wrap |
| line_pos | output | 10 | Integer position of the oscillator within the line |
| freq_word | output | FRAC+1 (13) | Oscillator increment (line-frequency control word) |
| locked | output | 1 | Loop is locked |
| pseudo_seen | output | 1 | Previous line contained a pseudo-sync edge |

## Verification
A wrong sign or gain in the loop filter does not show up in a single sample. It shows up at the ports as a mean line period that fails to match the sync period over 32 lines, or as locked never rising within the allowed line budget. A bad lock or timeout counter moves the cycle in which locked rises or falls. The bench brackets those cycles: at least 15 lines to acquire, still locked 1500 samples after sync is removed, and unlocked by 2700 samples. A corrupted pseudo-sync path shows up within two lines, either as a flag in a clean line or as a disturbed line period after the injected pulse.

// File: rtl/llk_pkg.sv
package llk_pkg;

  typedef enum logic {
    STD_50HZ = 1'b0,
    STD_60HZ = 1'b1
  } line_std_e;

  function automatic int unsigned tenth_of(input int unsigned n);
    return n / 10;
  endfunction

endpackage

// File: rtl/llk_sync_slicer.sv
module llk_sync_slicer #(
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [LW-1:0] luma,
  input  logic [LW-1:0] lvl,
  output logic          fall
);

  logic below;
  logic below_q;
  logic below_n;

  assign below = (luma < lvl);

  always_comb begin
    below_n = below_q;
    if (en) below_n = below;
  end

  // held high in reset so a low first sample is not an edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) below_q <= 1'b1;
    else        below_q <= below_n;
  end

  assign fall = en & below & ~below_q;

endmodule

// File: rtl/llk_line_nco.sv
module llk_line_nco #(
  parameter int CNTW = 10,
  parameter int FRAC = 12,
  parameter int IW   = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [CNTW-1:0] modulus,
  input  logic [IW-1:0]   inc,
  output logic            line_start,
  output logic [CNTW-1:0] line_pos
);

  localparam int AW = CNTW + FRAC;

  logic [AW-1:0] acc_q;
  logic [AW-1:0] acc_n;
  logic [AW:0]   sum;
  logic [AW:0]   span;
  logic [AW:0]   rem;
  logic          wrap;

  always_comb begin
    span  = {1'b0, modulus, {FRAC{1'b0}}};
    sum   = {1'b0, acc_q} + (AW+1)'(inc);
    rem   = sum - span;
    wrap  = en && (sum >= span);
    acc_n = acc_q;
    if (en) acc_n = wrap ? rem[AW-1:0] : sum[AW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q      <= '0;
      line_start <= 1'b0;
    end else begin
      acc_q      <= acc_n;
      line_start <= wrap;
    end
  end

  assign line_pos = acc_q[AW-1:FRAC];

  // R3
  no_double_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> !line_start);

endmodule

// File: rtl/llk_loop_filter.sv
module llk_loop_filter #(
  parameter int EW   = 11,
  parameter int FRAC = 12,
  parameter int SHW  = 4,
  parameter int IW   = 13
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 upd,
  input  logic                 hold,
  input  logic signed [EW-1:0] err,
  input  logic [SHW-1:0]       kp_sh,
  input  logic [SHW-1:0]       ki_sh,
  output logic [IW-1:0]        freq_word
);

  localparam int XW  = EW + FRAC + 2;
  localparam int LIM = 2 ** (FRAC - 1);
  localparam int NOM = 2 ** FRAC;
  localparam logic signed [XW:0]   LIM_P = (XW+1)'(LIM);
  localparam logic signed [XW:0]   LIM_M = -((XW+1)'(LIM));
  localparam logic signed [XW-1:0] NOM_X = XW'(NOM);

  logic signed [XW-1:0] integ_q, integ_n;
  logic signed [XW-1:0] u_q, u_n;
  logic signed [XW-1:0] scaled, p_term, i_term;
  logic signed [XW:0]   i_sum, u_sum;
  logic signed [XW-1:0] word_x;

  function automatic logic signed [XW-1:0] clip(input logic signed [XW:0] v);
    if (v > LIM_P)      return $signed(LIM_P[XW-1:0]);
    else if (v < LIM_M) return $signed(LIM_M[XW-1:0]);
    else                return $signed(v[XW-1:0]);
  endfunction

  always_comb begin
    scaled  = $signed({{(XW-EW){err[EW-1]}}, err}) <<< FRAC;
    p_term  = scaled >>> kp_sh;
    i_term  = scaled >>> ki_sh;
    i_sum   = $signed({integ_q[XW-1], integ_q}) + $signed({i_term[XW-1], i_term});
    integ_n = integ_q;
    u_n     = u_q;
    u_sum   = '0;
    if (upd) begin
      integ_n = clip(i_sum);
      u_sum   = $signed({integ_n[XW-1], integ_n}) + $signed({p_term[XW-1], p_term});
      u_n     = clip(u_sum);
    end else if (hold) begin
      u_n = integ_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      integ_q <= '0;
      u_q     <= '0;
    end else begin
      integ_q <= integ_n;
      u_q     <= u_n;
    end
  end

  assign word_x    = NOM_X - u_q;
  assign freq_word = word_x[IW-1:0];

  // R9
  freq_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(freq_word) >= NOM - LIM) && (int'(freq_word) <= NOM + LIM));

  // R6
  hold_uses_integ_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !upd) |=> (u_q == $past(integ_q)));

endmodule

// File: rtl/llk_phase_lock.sv
module llk_phase_lock #(
  parameter int CNTW         = 10,
  parameter int EW           = 11,
  parameter int WINW         = 8,
  parameter int LOCK_LINES   = 16,
  parameter int UNLOCK_LINES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 fall,
  input  logic                 line_start,
  input  logic [CNTW-1:0]      line_pos,
  input  logic [CNTW-1:0]      modulus,
  input  logic [CNTW-1:0]      half,
  input  logic [CNTW-1:0]      tenth,
  input  logic [CNTW-1:0]      tmo_lim,
  input  logic [WINW-1:0]      win,
  output logic                 accept,
  output logic signed [EW-1:0] err,
  output logic                 tmo,
  output logic                 locked,
  output logic                 pseudo_seen
);

  localparam int GCW = $clog2(LOCK_LINES + 1);
  localparam int BCW = $clog2(UNLOCK_LINES + 1);

  logic [EW-1:0]   mag;
  logic            reject, pseudo, in_win, line_evt;
  logic [CNTW-1:0] tcnt_q, tcnt_n;
  logic [GCW-1:0]  good_q, good_n;
  logic [BCW-1:0]  bad_q, bad_n;
  logic            locked_n;
  logic            pend_q, pend_n, seen_n;

  always_comb begin
    if (line_pos < half) err = $signed({1'b0, line_pos});
    else                 err = $signed({1'b0, line_pos}) - $signed({1'b0, modulus});
    mag      = err[EW-1] ? EW'(-err) : EW'(err);
    reject   = locked && (int'(mag) > int'(tenth));
    accept   = fall && !reject;
    pseudo   = fall && reject;
    tmo      = en && !accept && (tcnt_q >= tmo_lim - CNTW'(1));
    in_win   = accept && (int'(mag) <= int'(win));
    line_evt = accept || tmo;
  end

  // timeout counter: enabled samples since the last accepted edge
  always_comb begin
    tcnt_n = tcnt_q;
    if (en) begin
      if (line_evt) tcnt_n = '0;
      else          tcnt_n = tcnt_q + CNTW'(1);
    end
  end

  // lock qualification
  always_comb begin
    good_n = good_q;
    bad_n  = bad_q;
    if (line_evt) begin
      if (in_win) begin
        bad_n = '0;
        if (int'(good_q) < LOCK_LINES) good_n = good_q + GCW'(1);
      end else begin
        good_n = '0;
        if (int'(bad_q) < UNLOCK_LINES) bad_n = bad_q + BCW'(1);
      end
    end
    if (locked) locked_n = (int'(bad_n) < UNLOCK_LINES);
    else        locked_n = (int'(good_n) >= LOCK_LINES);
  end

  // per-line pseudo-sync report
  always_comb begin
    pend_n = pend_q | pseudo;
    seen_n = pseudo_seen;
    if (line_start) begin
      seen_n = pend_q | pseudo;
      pend_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt_q      <= '0;
      good_q      <= '0;
      bad_q       <= '0;
      locked      <= 1'b0;
      pend_q      <= 1'b0;
      pseudo_seen <= 1'b0;
    end else begin
      tcnt_q      <= tcnt_n;
      good_q      <= good_n;
      bad_q       <= bad_n;
      locked      <= locked_n;
      pend_q      <= pend_n;
      pseudo_seen <= seen_n;
    end
  end

  // R5
  lock_rise_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(accept));

  // R5
  lock_fall_on_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(tmo || fall));

  // R7
  flag_moves_at_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_start |=> $stable(pseudo_seen));

endmodule

// File: rtl/llk_line_lock.sv
module llk_line_lock #(
  parameter int LW           = 8,
  parameter int FRAC         = 12,
  parameter int SHW          = 4,
  parameter int WINW         = 8,
  parameter int LINE_50      = 432,
  parameter int LINE_60      = 429,
  parameter int LOCK_LINES   = 16,
  parameter int UNLOCK_LINES = 4
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  smp_en,
  input  logic [LW-1:0]                         luma,
  input  logic [LW-1:0]                         slice_lvl,
  input  logic                                  std60,
  input  logic [SHW-1:0]                        kp_shift,
  input  logic [SHW-1:0]                        ki_shift,
  input  logic [WINW-1:0]                       lock_win,
  output logic                                  line_start,
  output logic [$clog2((LINE_50*3)/2+1)-1:0]    line_pos,
  output logic [FRAC:0]                         freq_word,
  output logic                                  locked,
  output logic                                  pseudo_seen
);

  localparam int CNTW = $clog2((LINE_50 * 3) / 2 + 1);
  localparam int EW   = CNTW + 1;
  localparam int IW   = FRAC + 1;

  localparam logic [CNTW-1:0] MOD_50   = CNTW'(LINE_50);
  localparam logic [CNTW-1:0] MOD_60   = CNTW'(LINE_60);
  localparam logic [CNTW-1:0] HALF_50  = CNTW'(LINE_50 / 2);
  localparam logic [CNTW-1:0] HALF_60  = CNTW'(LINE_60 / 2);
  localparam logic [CNTW-1:0] TENTH_50 = CNTW'(llk_pkg::tenth_of(LINE_50));
  localparam logic [CNTW-1:0] TENTH_60 = CNTW'(llk_pkg::tenth_of(LINE_60));
  localparam logic [CNTW-1:0] TMO_50   = CNTW'((LINE_50 * 3) / 2);
  localparam logic [CNTW-1:0] TMO_60   = CNTW'((LINE_60 * 3) / 2);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  // line standard selection
  llk_pkg::line_std_e std_sel;
  logic [CNTW-1:0]    modulus, half, tenth, tmo_lim;

  assign std_sel = llk_pkg::line_std_e'(std60);

  always_comb begin
    if (std_sel == llk_pkg::STD_60HZ) begin
      modulus = MOD_60;  half = HALF_60;  tenth = TENTH_60;  tmo_lim = TMO_60;
    end else begin
      modulus = MOD_50;  half = HALF_50;  tenth = TENTH_50;  tmo_lim = TMO_50;
    end
  end

  logic                 fall;
  logic                 accept;
  logic                 tmo;
  logic signed [EW-1:0] err;
  logic [IW-1:0]        inc;

  llk_sync_slicer #(.LW(LW)) u_slicer (
    .clk   (clk),
    .rst_n (rst_s_n),
    .en    (smp_en),
    .luma  (luma),
    .lvl   (slice_lvl),
    .fall  (fall)
  );

  llk_phase_lock #(
    .CNTW         (CNTW),
    .EW           (EW),
    .WINW         (WINW),
    .LOCK_LINES   (LOCK_LINES),
    .UNLOCK_LINES (UNLOCK_LINES)
  ) u_phase (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .en          (smp_en),
    .fall        (fall),
    .line_start  (line_start),
    .line_pos    (line_pos),
    .modulus     (modulus),
    .half        (half),
    .tenth       (tenth),
    .tmo_lim     (tmo_lim),
    .win         (lock_win),
    .accept      (accept),
    .err         (err),
    .tmo         (tmo),
    .locked      (locked),
    .pseudo_seen (pseudo_seen)
  );

  llk_loop_filter #(
    .EW   (EW),
    .FRAC (FRAC),
    .SHW  (SHW),
    .IW   (IW)
  ) u_filter (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .upd       (accept),
    .hold      (tmo),
    .err       (err),
    .kp_sh     (kp_shift),
    .ki_sh     (ki_shift),
    .freq_word (inc)
  );

  llk_line_nco #(
    .CNTW (CNTW),
    .FRAC (FRAC),
    .IW   (IW)
  ) u_nco (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .en         (smp_en),
    .modulus    (modulus),
    .inc        (inc),
    .line_start (line_start),
    .line_pos   (line_pos)
  );

  assign freq_word = inc;

endmodule

// File: tb/test_llk_line_lock.sv
module test_llk_line_lock;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       smp_en;
  logic [7:0] luma;
  logic [7:0] slice_lvl;
  logic       std60;
  logic [3:0] kp_shift;
  logic [3:0] ki_shift;
  logic [7:0] lock_win;
  logic       line_start;
  logic [9:0] line_pos;
  logic [12:0] freq_word;
  logic       locked;
  logic       pseudo_seen;

  always #10 clk = ~clk;

  llk_line_lock i_llk_line_lock (
    .clk         (clk),
    .rst_n       (rst_n),
    .smp_en      (smp_en),
    .luma        (luma),
    .slice_lvl   (slice_lvl),
    .std60       (std60),
    .kp_shift    (kp_shift),
    .ki_shift    (ki_shift),
    .lock_win    (lock_win),
    .line_start  (line_start),
    .line_pos    (line_pos),
    .freq_word   (freq_word),
    .locked      (locked),
    .pseudo_seen (pseudo_seen)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  // sync generator
  int       period = 432;
  bit       gen_on = 1'b0;
  bit       ps_arm = 1'b0;
  bit       ovr_en = 1'b0;
  logic [7:0] ovr_val = 8'd200;
  int       gcnt   = 0;

  initial begin
    luma = 8'd200;
    forever begin
      @(negedge clk);
      if (ovr_en)                                   luma = ovr_val;
      else if (gen_on && gcnt < 32)                 luma = 8'd16;
      else if (ps_arm && gcnt >= 200 && gcnt < 208) luma = 8'd16;
      else                                          luma = 8'd200;
      if (gcnt == 208) ps_arm = 1'b0;
      gcnt = (gcnt + 1 >= period) ? 0 : gcnt + 1;
    end
  end

  // output monitor
  int since = 0, last_iv = 0, ls_cnt = 0, tot = 0, ps_ones = 0, range_bad = 0;
  int last_ps = 0;
  bit ls_d = 1'b0;

  initial begin
    forever begin
      @(negedge clk);
      since++;
      if (rst_n && (freq_word < 13'd2048 || freq_word > 13'd6144)) range_bad++;
      if (ls_d) begin
        last_ps = int'(pseudo_seen);
        if (pseudo_seen) ps_ones++;
      end
      if (line_start) begin
        last_iv = since;
        since   = 0;
        ls_cnt++;
        tot += last_iv;
      end
      ls_d = line_start;
    end
  end

  task automatic wait_lines(input int n);
    int tgt;
    tgt = ls_cnt + n;
    while (ls_cnt < tgt) @(negedge clk);
  endtask

  task automatic wait_lock(input int maxl, output int used);
    used = 0;
    while (!locked && used < maxl) begin
      wait_lines(1);
      used++;
    end
  endtask

  task automatic mean_check(input int lines, input int per, input int tol, input string req);
    int t0, s;
    t0 = tot;
    wait_lines(lines);
    s = tot - t0;
    chk((s >= lines * per - tol) && (s <= lines * per + tol), req,
        "sum of line periods", s, lines * per);
  endtask

  // watchdog
  initial begin
    repeat (195000) @(negedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 195000, 0);
    finish_run();
  end

  initial begin
    int used, t0, ones0;
    rst_n = 1'b0; smp_en = 1'b1; slice_lvl = 8'd100; std60 = 1'b0;
    kp_shift = 4'd10; ki_shift = 4'd12; lock_win = 8'd2;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(locked == 1'b0, "R1", "locked", int'(locked), 0);
    chk(pseudo_seen == 1'b0, "R1", "pseudo_seen", int'(pseudo_seen), 0);
    chk(freq_word == 13'd4096, "R1", "freq_word", int'(freq_word), 4096);
    chk(line_start == 1'b0, "R1", "line_start", int'(line_start), 0);

    // R3 free run, 432-sample lines
    wait_lines(1);
    t0 = tot; wait_lines(3);
    chk(tot - t0 == 1296, "R3", "3 free lines at 50Hz", tot - t0, 1296);
    chk(freq_word == 13'd4096, "R3", "free-run freq_word", int'(freq_word), 4096);

    // R10 enable gap lengthens the line
    repeat (50) @(negedge clk);
    smp_en = 1'b0;
    repeat (100) @(negedge clk);
    smp_en = 1'b1;
    wait_lines(1);
    chk(last_iv == 532, "R10", "line with 100-cycle gap", last_iv, 532);

    // R3 free run, 429-sample lines
    std60 = 1'b1;
    wait_lines(1);
    t0 = tot; wait_lines(3);
    chk(tot - t0 == 1287, "R3", "3 free lines at 60Hz", tot - t0, 1287);
    std60 = 1'b0;
    wait_lines(2);

    // R2 level equal to threshold is not an edge
    repeat (100) @(negedge clk);
    ovr_val = 8'd100; ovr_en = 1'b1;
    repeat (20) @(negedge clk);
    ovr_en = 1'b0;
    wait_lines(1);
    chk(last_iv == 432, "R2", "line with luma at threshold", last_iv, 432);

    // R2/R8 a true crossing while unlocked steers the loop, no flag
    repeat (100) @(negedge clk);
    ovr_val = 8'd50; ovr_en = 1'b1;
    repeat (20) @(negedge clk);
    ovr_en = 1'b0;
    wait_lines(1);
    repeat (2) @(negedge clk);
    chk(last_iv > 432, "R2", "line lengthened by late edge", last_iv, 433);
    chk(last_ps == 0, "R8", "pseudo flag while unlocked", last_ps, 0);
    chk(locked == 1'b0, "R8", "still unlocked", int'(locked), 0);

    // R5 acquire lock on 432-sample sync
    period = 432; gen_on = 1'b1;
    wait_lock(100, used);
    chk(locked == 1'b1, "R5", "locked on 432 sync", int'(locked), 1);
    chk(used >= 15, "R5", "lines before lock", used, 16);
    wait_lines(2);
    mean_check(32, 432, 6, "R4");
    chk(locked == 1'b1, "R5", "lock held at 432", int'(locked), 1);

    // R4 slower sync pulls the control word down
    period = 434;
    wait_lines(60);
    chk(locked == 1'b1, "R5", "locked on 434 sync", int'(locked), 1);
    mean_check(32, 434, 8, "R4");
    chk(freq_word >= 13'd4040 && freq_word <= 13'd4095, "R4",
        "freq_word for slow sync", int'(freq_word), 4077);

    // R7 pseudo-sync flagged once, loop undisturbed
    ones0 = ps_ones;
    ps_arm = 1'b1;
    t0 = tot;
    wait_lines(4);
    repeat (2) @(negedge clk);
    chk(ps_ones - ones0 == 1, "R7", "lines flagged after one pseudo pulse", ps_ones - ones0, 1);
    chk(locked == 1'b1, "R7", "lock kept over pseudo pulse", int'(locked), 1);
    chk((tot - t0 >= 4 * 434 - 6) && (tot - t0 <= 4 * 434 + 6), "R7",
        "line periods around pseudo pulse", tot - t0, 4 * 434);
    wait_lines(2);
    repeat (2) @(negedge clk);
    chk(last_ps == 0, "R7", "flag clear on clean line", last_ps, 0);

    // R6/R5 sync removed: timeouts, then unlock, then integrator free run
    while (gcnt != 40) @(negedge clk);
    gen_on = 1'b0;
    repeat (1500) @(negedge clk);
    chk(locked == 1'b1, "R5", "lock after two timeouts", int'(locked), 1);
    repeat (1200) @(negedge clk);
    chk(locked == 1'b0, "R6", "lock after four timeouts", int'(locked), 0);
    wait_lines(2);
    chk(last_iv >= 432 && last_iv <= 436, "R6", "free-run period on integrator", last_iv, 434);

    // R3/R5 lock on 429-sample sync
    std60 = 1'b1; period = 429; gen_on = 1'b1;
    wait_lock(120, used);
    chk(locked == 1'b1, "R5", "locked on 429 sync", int'(locked), 1);
    mean_check(32, 429, 6, "R3");

    chk(range_bad == 0, "R9", "freq_word range violations", range_bad, 0);
    finish_run();
  end

endmodule